// File: doc/BRIEF.md
# Two-Strobe Transmit Word Buffer with Parity Insertion

This block is the host-facing half of a serial-bus transmitter. A processor writes each 32-bit transmit word as two 16-bit halves. One strobe captures the lower half. A second strobe captures the upper half and commits the assembled word into a 32-entry first-in first-out buffer in the same clock edge. When parity insertion is enabled, the most significant bit of the committed word is replaced by an odd or even parity bit over the remaining 31 bits. When it is disabled, all 32 bits are stored unchanged.

A downstream shift-out stage drains the buffer through a valid/ready handshake and always receives the oldest word first. Three status outputs support block-oriented software. An idle flag reports an empty buffer. A room flag reports that a block of 16 more words fits. An active-low full flag reports that no slot is free. Load attempts made while the buffer is full are dropped without any side effect.

All strobes are single-cycle synchronous enables in the `clk` domain.

Top module: `txw_loader`

## Requirements
- R1: A cycle with `ld_first` high latches `din` as the lower half (bits 15..0). A cycle with `ld_second` high commits the word {`din`, latched lower half} at that clock edge. The committed word is visible on `tx_word` with `tx_valid` high from the next cycle on, when the buffer was empty.
- R2: `ld_second` without a fresh `ld_first` reuses the most recently latched lower half. When both strobes are high in the same cycle, the lower half of the committed word is also taken from `din`.
- R3: Words leave the buffer in commit order, and up to 32 words are held.
- R4: `full_n` is low exactly while 32 words are held. A commit attempted while 32 words are held at the start of that cycle is ignored, even if a pop happens in the same cycle.
- R5: `tx_idle` is high exactly while the buffer holds no word, and `tx_valid` is high exactly while it holds at least one.
- R6: `half_room` is high while fewer than 16 words are held, and low at 16 or more.
- R7: With `par_on` high, bit 31 of the committed word is replaced by a parity bit over bits 30..0. `par_even`=0 selects odd parity, so the 32-bit word has an odd count of ones. `par_even`=1 selects even parity, so the word has an even count of ones.
- R8: With `par_on` low, all 32 assembled bits are stored unchanged.
- R9: Parity uses the `par_on` and `par_even` values present in the commit cycle. Later changes do not alter a stored word.
- R10: `tx_valid` and `tx_ready` both high at a clock edge remove the oldest word. An accepted commit and a pop in the same cycle leave the word count unchanged.
- R11: After synchronous reset (`rst_n` low at an edge), the buffer is empty: `tx_idle`=1, `half_room`=1, `full_n`=1 and `tx_valid`=0. The latched lower half is also cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 16 | Half-word data from the host |
| ld_first | input | 1 | Latch `din` as the lower half |
| ld_second | input | 1 | Take `din` as the upper half and commit the word |
| par_on | input | 1 | Enable parity insertion in bit 31 |
| par_even | input | 1 | Parity kind: 0 odd, 1 even |
| tx_ready | input | 1 | Downstream stage takes the presented word |
| tx_word | output | 32 | Oldest buffered word |
| tx_valid | output | 1 | `tx_word` holds a buffered word |
| tx_idle | output | 1 | High when the buffer is empty |
| half_room | output | 1 | High while fewer than 16 words are held |
| full_n | output | 1 | Low when all 32 slots are held |

## Verification
The word path is driven with plain two-strobe loads and drained in several ways:
- with parity off, odd and even, each of which changes only bit 31;
- by flipping the parity kind after a commit, which separates commit-time from pop-time parity;
- with a lone second-half strobe straight after reset, and with both strobes in one cycle, which tells the reused lower half apart from a fresh one.

The occupancy path is filled one word at a time through the 15/16 boundary and up to 32, then overloaded. This shows that dropped loads leave no trace in the drained order. Simultaneous pop and commit is tried at 16 words, where the count must hold, and at 32 words, where the commit must be dropped and the count must fall to 31.

// File: rtl/txw_pkg.sv
// Shared types for the transmit word buffer.
// Assumes: parity kind is one bit, 0 meaning odd and 1 meaning even.
package txw_pkg;

    typedef enum logic {
        PAR_ODD  = 1'b0,
        PAR_EVEN = 1'b1
    } par_kind_e;

    typedef struct packed {
        logic      en;
        par_kind_e kind;
    } par_cfg_t;

endpackage

// File: rtl/txw_assemble.sv
// Assembles a word from two half strobes and inserts parity in the top bit.
// Assumes: strobes are single-cycle synchronous enables; when both strobes
// are high together, the lower half is taken from the current data input.
module txw_assemble
    import txw_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HALF_W-1:0]     din,
    input  logic                  ld_first,
    input  logic                  ld_second,
    input  par_cfg_t              cfg,
    output logic                  push_o,
    output logic [2*HALF_W-1:0]   word_o
);
    localparam int WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] lo_use;
    logic [WORD_W-1:0] raw;
    logic              par_bit;

    // Hold the most recent lower half until the next first-half strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (ld_first)
            lo_q <= din;
    end

    // Pick the lower half and build the raw word.
    always_comb begin
        lo_use = ld_first ? din : lo_q;
        raw    = {din, lo_use};
    end

    // Compute the parity bit over all bits below the top one.
    always_comb begin
        if (cfg.kind == PAR_EVEN)
            par_bit = ^raw[WORD_W-2:0];
        else
            par_bit = ~^raw[WORD_W-2:0];
    end

    // Replace the top bit when parity is enabled.
    always_comb begin
        word_o = raw;
        if (cfg.en)
            word_o[WORD_W-1] = par_bit;
        push_o = ld_second;
    end

    // R7
    odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && cfg.en && cfg.kind == PAR_ODD) |-> (^word_o) == 1'b1);

    // R7
    even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && cfg.en && cfg.kind == PAR_EVEN) |-> (^word_o) == 1'b0);

    // R2
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_first |=> $stable(lo_q));

endmodule

// File: rtl/txw_store.sv
// Circular word buffer with a valid/ready read side.
// Assumes: a push is dropped when the buffer is full at the start of the
// cycle, regardless of a pop in the same cycle.
module txw_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [WORD_W-1:0]           wdata,
    input  logic                        pop_req,
    output logic [WORD_W-1:0]           rdata,
    output logic                        valid,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam bit   POW2 = (DEPTH == (1 << PTR_W));

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W-1:0]  wr_nxt, rd_nxt;
    logic              push_ok, pop_ok;

    assign push_ok = push && (count != FULL_CNT);
    assign pop_ok  = pop_req && (count != '0);

    // Pointer wrap logic chosen by whether the depth is a power of two.
    generate
        if (POW2) begin : g_wrap_free
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Write an accepted word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= wr_nxt;
            if (pop_ok)
                rd_ptr <= rd_nxt;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the oldest word.
    always_comb begin
        rdata = mem[rd_ptr];
        valid = (count != '0);
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R4
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push) |=> $stable(wr_ptr));

    // R10
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop_req && count != '0 && count != FULL_CNT) |=> $stable(count));

    // R3
    order_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && valid) |=> (rd_ptr != $past(rd_ptr)));

endmodule

// File: rtl/txw_flags.sv
// Derives the host status flags from buffer occupancy.
// Assumes: occupancy never exceeds the depth.
module txw_flags #(
    parameter int DEPTH = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        idle,
    output logic                        room,
    output logic                        full_n
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] MARK     = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Decode occupancy into active-high idle/room and active-low full.
    always_comb begin
        idle   = (count == '0);
        room   = (count < MARK);
        full_n = (count != FULL_CNT);
    end

    // R6
    full_no_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !room);

    // R5
    idle_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (room && full_n));

endmodule

// File: rtl/txw_loader.sv
// Top: host loads words as two halves; words are buffered and handed on.
// Assumes: all inputs are synchronous to clk; reset is synchronous active-low.
module txw_loader
    import txw_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HALF_W-1:0]     din,
    input  logic                  ld_first,
    input  logic                  ld_second,
    input  logic                  par_on,
    input  logic                  par_even,
    input  logic                  tx_ready,
    output logic [2*HALF_W-1:0]   tx_word,
    output logic                  tx_valid,
    output logic                  tx_idle,
    output logic                  half_room,
    output logic                  full_n
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    par_cfg_t          cfg;
    logic              push;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  count;

    // Pack the parity controls into the shared config type.
    always_comb begin
        cfg.en   = par_on;
        cfg.kind = par_kind_e'(par_even);
    end

    txw_assemble #(.HALF_W(HALF_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .ld_first  (ld_first),
        .ld_second (ld_second),
        .cfg       (cfg),
        .push_o    (push),
        .word_o    (word)
    );

    txw_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wdata   (word),
        .pop_req (tx_ready),
        .rdata   (tx_word),
        .valid   (tx_valid),
        .count   (count)
    );

    txw_flags #(.DEPTH(DEPTH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (count),
        .idle   (tx_idle),
        .room   (half_room),
        .full_n (full_n)
    );

    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid != tx_idle);

    // R1
    commit_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_second && tx_idle) |=> tx_valid);

    // R11
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (tx_idle && !tx_valid && full_n && half_room));

endmodule

// File: tb/txw_loader_bench.sv
module txw_loader_bench;
    localparam int CLK_P = 10;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic        ld_first = 1'b0, ld_second = 1'b0;
    logic        par_on = 1'b0, par_even = 1'b0;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_word;
    logic        tx_valid, tx_idle, half_room, full_n;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] q[$];
    logic [15:0] lat = '0;

    always #(CLK_P/2) clk = ~clk;

    txw_loader u_txw_loader (
        .clk(clk), .rst_n(rst_n), .din(din), .ld_first(ld_first),
        .ld_second(ld_second), .par_on(par_on), .par_even(par_even),
        .tx_ready(tx_ready), .tx_word(tx_word), .tx_valid(tx_valid),
        .tx_idle(tx_idle), .half_room(half_room), .full_n(full_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [15:0] hi, input logic [15:0] lo);
        logic [31:0] w;
        w = {hi, lo};
        if (par_on) w[31] = par_even ? ^w[30:0] : ~^w[30:0];
        return w;
    endfunction

    // Scoreboard monitor: compare each handed-over word with the oldest expected.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (q.size() == 0)
                chk(1'b0, "R3 unexpected word", tx_word, 32'h0);
            else begin
                chk(tx_word === q[0], "R1/R3/R7/R8 word", tx_word, q[0]);
                void'(q.pop_front());
            end
        end
    end

    // Driver: one strobe cycle, pushes the expected word on an accepted commit.
    task automatic strobe(input bit f, input bit s, input logic [15:0] d);
        @(posedge clk); #1;
        ld_first = f; ld_second = s; din = d;
        if (s && q.size() < DEPTH) q.push_back(mk(d, f ? d : lat));
        if (f) lat = d;
        @(posedge clk); #1;
        ld_first = 1'b0; ld_second = 1'b0;
    endtask

    task automatic load(input logic [15:0] hi, input logic [15:0] lo);
        strobe(1'b1, 1'b0, lo);
        strobe(1'b0, 1'b1, hi);
    endtask

    task automatic flags(input int n, input string tag);
        @(negedge clk);
        chk(tx_idle == (n == 0), {tag, " R5 idle"}, 32'(tx_idle), 32'(n == 0));
        chk(tx_valid == (n != 0), {tag, " R5 valid"}, 32'(tx_valid), 32'(n != 0));
        chk(half_room == (n < 16), {tag, " R6 room"}, 32'(half_room), 32'(n < 16));
        chk(full_n == (n != DEPTH), {tag, " R4 full_n"}, 32'(full_n), 32'(n != DEPTH));
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        @(posedge clk); #1; tx_ready = 1'b1;
        do begin @(negedge clk); guard++; end while (q.size() != 0 && guard < 200);
        @(posedge clk); #1; tx_ready = 1'b0;
        chk(q.size() == 0, {tag, " R3 all words seen"}, 32'(q.size()), 32'h0);
        flags(0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        flags(0, "R11 reset");

        // R11/R2: lone second half after reset uses a cleared lower half; R8 passthrough
        strobe(1'b0, 1'b1, 16'hA5A5);
        load(16'hFFFF, 16'h1234);
        strobe(1'b0, 1'b1, 16'h0F0F);      // R2 reuse 1234
        strobe(1'b1, 1'b1, 16'h5AA5);      // R2 both strobes in one cycle
        flags(4, "R1 four held");
        drain("R8");

        // R7 odd then even with a ready downstream
        par_on = 1'b1; par_even = 1'b0;
        tx_ready = 1'b1;
        load(16'h0000, 16'h0001);
        load(16'h8000, 16'h0000);
        par_even = 1'b1;
        load(16'h7FFF, 16'hFFFF);
        load(16'h0000, 16'h0003);
        drain("R7");

        // R9: parity kind changed after commit must not matter
        par_even = 1'b0;
        load(16'h1357, 16'h2468);
        @(posedge clk); #1; par_even = 1'b1; par_on = 1'b0;
        drain("R9");

        // R6/R4 fill through the boundaries, then overload
        for (int i = 0; i < 15; i++) load(16'(i), 16'(i * 3 + 1));
        flags(15, "R6 fifteen");
        load(16'hBEEF, 16'h0016);
        flags(16, "R6 sixteen");
        for (int i = 16; i < DEPTH; i++) load(16'(i << 4), 16'(~i));
        flags(32, "R4 full");
        load(16'hDEAD, 16'hDEAD);
        load(16'hCAFE, 16'hCAFE);
        flags(32, "R4 ignored");
        // R4: pop and commit together while full -> commit dropped
        @(posedge clk); #1;
        tx_ready = 1'b1; ld_second = 1'b1; din = 16'h7777;
        if (q.size() < DEPTH) q.push_back(mk(16'h7777, lat));
        @(posedge clk); #1;
        tx_ready = 1'b0; ld_second = 1'b0;
        flags(31, "R4 full pop+commit");
        drain("R4");

        // R10: pop and commit together at sixteen keep the count
        for (int i = 0; i < 16; i++) load(16'(i + 100), 16'(i + 200));
        flags(16, "R10 before");
        @(posedge clk); #1;
        tx_ready = 1'b1; ld_second = 1'b1; din = 16'h4242;
        if (q.size() < DEPTH) q.push_back(mk(16'h4242, lat));
        @(posedge clk); #1;
        tx_ready = 1'b0; ld_second = 1'b0;
        flags(16, "R10 same cycle");
        @(posedge clk); #1; tx_ready = 1'b1;
        @(posedge clk); #1; tx_ready = 1'b0;
        flags(15, "R10 single pop");
        drain("R10");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule